// File: doc/BRIEF.md
# Sixteen-bit two-level lookahead adder

This block adds two 16-bit unsigned or two's-complement operands and a carry-in in a single combinational path. The operands are split into four 4-bit groups. Inside each group, every carry is formed as a flat sum of products of the bit generate and propagate terms. Each group also reduces its bit terms to one group generate and one group propagate.

A second lookahead level takes the four group terms and the carry-in and forms the carry into every group and the final carry-out in the same flat way. No carry passes from one group to the next. The block also exports its own 16-bit-wide propagate and generate terms. A wider adder can therefore place this block under a third lookahead level.

The block holds no state and has no clock. A result follows its inputs within the same evaluation step.

Top module: `lookahead_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of `op_a + op_b + carry_in`.
- R2: `carry_out` equals bit 16 of the 17-bit total `op_a + op_b + carry_in`.
- R3: `blk_prop` is 1 exactly when, at every bit position, at least one of the two operand bits is 1, that is, when `&(op_a | op_b)` holds.
- R4: `blk_gen` is 1 exactly when `op_a + op_b` with no carry-in reaches 65536 or more.
- R5: When every bit position propagates and `carry_in` is 1, the carry-in travels to `carry_out`. For example, 16'hFFFF plus 16'h0000 with carry-in 1 gives sum 0 and carry-out 1.
- R6: `carry_in` has no effect on `blk_prop` or `blk_gen`. The same operands give the same block terms for either carry-in value.
- R7: A carry created in any group reaches every higher group. For example, 16'h0FFF plus 16'h0001 gives 16'h1000, and 16'h000F plus 16'h0001 gives 16'h0010.
- R8: The outputs depend only on the present inputs. They settle without any clock edge, and earlier operands leave no trace in them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |
| blk_prop | output | 1 | Block propagate: a carry-in would pass through all 16 bits |
| blk_gen | output | 1 | Block generate: the operands alone produce a carry-out |

## Verification
The embedded checks are immediate checks inside combinational processes. They assume the operands are two-state and hold still while the lookahead terms settle, so each check sees the fully resolved values. The bench changes the inputs only just after a rising edge of its own clock and compares the results at the falling edge. It never drives X or Z on the operands.

The stimulus covers three groups of cases. The first are directed patterns that make a carry start in one group and cross the others. The second are full-propagate operands with each carry-in value. The third are random operand pairs. Each case is checked against a plain 17-bit addition done in the bench.

// File: rtl/cla_pkg.sv
// Package cla_pkg
// Holds the sizing constants and a flat carry-expansion function shared by
// the adder groups. Assumes two-state operands.
package cla_pkg;
    localparam int GRP_W  = 4;
    localparam int N_GRP  = 4;
    localparam int DATA_W = GRP_W * N_GRP;

    // Returns carries c[0]..c[GRP_W]. Each carry is a flat OR of products
    // of generate/propagate terms; no carry depends on another carry.
    function automatic logic [GRP_W:0] expand_carries(
        input logic [GRP_W-1:0] gen,
        input logic [GRP_W-1:0] prop,
        input logic             cin
    );
        logic [GRP_W:0] c;
        logic           term;
        c    = '0;
        c[0] = cin;
        for (int j = 0; j < GRP_W; j++) begin
            for (int k = 0; k <= j; k++) begin
                term = gen[k];
                for (int m = k + 1; m <= j; m++) term = term & prop[m];
                c[j+1] = c[j+1] | term;
            end
            term = cin;
            for (int m = 0; m <= j; m++) term = term & prop[m];
            c[j+1] = c[j+1] | term;
        end
        return c;
    endfunction
endpackage

// File: rtl/cla_bit_pg.sv
// Module cla_bit_pg
// Forms the per-bit generate (a AND b) and propagate (a OR b) terms.
// Assumes: purely combinational, two-state inputs.
module cla_bit_pg #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] gen_o,
    output logic [W-1:0] prop_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen_o[i]  = a_i[i] & b_i[i];
        assign prop_o[i] = a_i[i] | b_i[i];
    end

    // Check: a bit that generates must also propagate.
    always_comb begin
        a_r3_gen_within_prop: assert ((gen_o & ~prop_o) == '0)
            else $error("R3: generate set without propagate");
    end
endmodule

// File: rtl/cla_group.sv
// Module cla_group
// One 4-bit lookahead group. It expands every internal carry flat from the
// bit terms and its carry-in, forms the sum bits, and reduces the bit terms
// to a group generate and a group propagate.
// Assumes: carry-in comes from the second lookahead level.
module cla_group
    import cla_pkg::*;
(
    input  logic [GRP_W-1:0] gen_i,
    input  logic [GRP_W-1:0] prop_i,
    input  logic             cin_i,
    output logic [GRP_W-1:0] sum_o,
    output logic             grp_gen_o,
    output logic             grp_prop_o
);
    logic [GRP_W:0] carries;
    logic [GRP_W:0] carries_nocin;
    logic [GRP_W-1:0] half_sum;

    // Flat internal carries, with and without the group carry-in.
    always_comb begin
        carries       = expand_carries(gen_i, prop_i, cin_i);
        carries_nocin = expand_carries(gen_i, prop_i, 1'b0);
    end

    // a XOR b equals propagate AND NOT generate.
    assign half_sum   = prop_i & ~gen_i;
    assign sum_o      = half_sum ^ carries[GRP_W-1:0];
    assign grp_gen_o  = carries_nocin[GRP_W];
    assign grp_prop_o = &prop_i;

    // Check: the group's own carry-out agrees with its reduced G/P terms.
    always_comb begin
        a_r7_group_terms: assert (carries[GRP_W] == (grp_gen_o | (grp_prop_o & cin_i)))
            else $error("R7: group carry-out disagrees with group G/P");
    end
endmodule

// File: rtl/cla_lookahead.sv
// Module cla_lookahead
// Second lookahead level. It forms the carry into every group and the final
// carry-out flat from the group terms and c0, and it exports block-level
// generate and propagate terms for a further lookahead level.
// Assumes: the group terms are already resolved.
module cla_lookahead #(
    parameter int N = 4
) (
    input  logic [N-1:0] grp_gen_i,
    input  logic [N-1:0] grp_prop_i,
    input  logic         cin_i,
    output logic [N-1:0] grp_cin_o,
    output logic         cout_o,
    output logic         blk_gen_o,
    output logic         blk_prop_o
);
    logic [N:0] c;
    logic       bg;

    // Flat carry into each group and the block generate.
    always_comb begin
        logic term;
        c    = '0;
        bg   = 1'b0;
        c[0] = cin_i;
        for (int j = 0; j < N; j++) begin
            for (int k = 0; k <= j; k++) begin
                term = grp_gen_i[k];
                for (int m = k + 1; m <= j; m++) term = term & grp_prop_i[m];
                c[j+1] = c[j+1] | term;
                if (j == N - 1) bg = bg | term;
            end
            term = cin_i;
            for (int m = 0; m <= j; m++) term = term & grp_prop_i[m];
            c[j+1] = c[j+1] | term;
        end
    end

    assign grp_cin_o  = c[N-1:0];
    assign cout_o     = c[N];
    assign blk_gen_o  = bg;
    assign blk_prop_o = &grp_prop_i;

    // Check: the carry-out follows the block terms.
    always_comb begin
        a_r5_prop_passes_cin: assert (!(blk_prop_o && cin_i) || cout_o)
            else $error("R5: full propagate lost the carry-in");
        a_r4_no_prop_means_gen: assert (blk_prop_o || (cout_o == blk_gen_o))
            else $error("R4: carry-out differs from block generate");
    end
endmodule

// File: rtl/lookahead_adder16.sv
// Module lookahead_adder16
// Top level of the 16-bit two-level lookahead adder. Bit terms feed four
// groups; the second level supplies each group carry-in directly.
// Assumes: purely combinational; no clock or reset.
module lookahead_adder16
    import cla_pkg::*;
(
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    input  logic        carry_in,
    output logic [15:0] sum_o,
    output logic        carry_out,
    output logic        blk_prop,
    output logic        blk_gen
);
    logic [DATA_W-1:0] bit_gen;
    logic [DATA_W-1:0] bit_prop;
    logic [N_GRP-1:0]  grp_gen;
    logic [N_GRP-1:0]  grp_prop;
    logic [N_GRP-1:0]  grp_cin;

    cla_bit_pg #(.W(DATA_W)) u_pg (
        .a_i    (op_a),
        .b_i    (op_b),
        .gen_o  (bit_gen),
        .prop_o (bit_prop)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        cla_group u_grp (
            .gen_i      (bit_gen[g*GRP_W +: GRP_W]),
            .prop_i     (bit_prop[g*GRP_W +: GRP_W]),
            .cin_i      (grp_cin[g]),
            .sum_o      (sum_o[g*GRP_W +: GRP_W]),
            .grp_gen_o  (grp_gen[g]),
            .grp_prop_o (grp_prop[g])
        );
    end

    cla_lookahead #(.N(N_GRP)) u_la (
        .grp_gen_i  (grp_gen),
        .grp_prop_i (grp_prop),
        .cin_i      (carry_in),
        .grp_cin_o  (grp_cin),
        .cout_o     (carry_out),
        .blk_gen_o  (blk_gen),
        .blk_prop_o (blk_prop)
    );

    // Check: the lookahead result equals a plain 17-bit addition.
    always_comb begin
        a_r1_total_matches: assert ({carry_out, sum_o} ==
                                    ({1'b0, op_a} + {1'b0, op_b} + {16'd0, carry_in}))
            else $error("R1: lookahead total differs from addition");
    end
endmodule

// File: tb/lookahead_adder16_test.sv
// Bench for lookahead_adder16: behavioural 17-bit reference, compared every clock.
module lookahead_adder16_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum_o;
    logic        carry_out;
    logic        blk_prop;
    logic        blk_gen;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    lookahead_adder16 uut (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .sum_o(sum_o), .carry_out(carry_out),
        .blk_prop(blk_prop), .blk_gen(blk_gen)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    task automatic check_val(input string req, input string what,
                             input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (a=%h b=%h cin=%0d)",
                     req, what, act, exp, op_a, op_b, carry_in);
        end
    endtask

    // Apply one vector after a rising edge and compare at the falling edge.
    task automatic run_vec(input logic [15:0] a, input logic [15:0] b,
                           input logic cin, input string req);
        logic [16:0] total;
        logic [16:0] nocin;
        @(posedge clk);
        #1;
        op_a = a; op_b = b; carry_in = cin;
        total = {1'b0, a} + {1'b0, b} + {16'd0, cin};
        nocin = {1'b0, a} + {1'b0, b};
        @(negedge clk);
        check_val({req, "/R1"}, "sum", int'(sum_o), int'(total[15:0]));
        check_val({req, "/R2"}, "carry_out", int'(carry_out), int'(total[16]));
        check_val({req, "/R3"}, "blk_prop", int'(blk_prop), int'(&(a | b)));
        check_val({req, "/R4"}, "blk_gen", int'(blk_gen), int'(nocin[16]));
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic p0, g0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Quiet state: zero inputs.
        @(negedge clk);
        check_val("R8", "idle sum", int'(sum_o), 0);
        check_val("R8", "idle carry_out", int'(carry_out), 0);
        check_val("R8", "idle blk_prop", int'(blk_prop), 0);
        check_val("R8", "idle blk_gen", int'(blk_gen), 0);

        run_vec(16'hFFFF, 16'h0001, 1'b0, "R2");
        run_vec(16'hFFFF, 16'h0000, 1'b1, "R5");
        run_vec(16'hFFFF, 16'hFFFF, 1'b1, "R5");
        run_vec(16'h8000, 16'h8000, 1'b0, "R4");
        run_vec(16'h000F, 16'h0001, 1'b0, "R7");
        run_vec(16'h00FF, 16'h0001, 1'b0, "R7");
        run_vec(16'h0FFF, 16'h0001, 1'b0, "R7");
        run_vec(16'h0F00, 16'h0100, 1'b0, "R7");
        run_vec(16'h5555, 16'hAAAA, 1'b0, "R3");
        run_vec(16'h5555, 16'hAAAA, 1'b1, "R5");
        run_vec(16'h1234, 16'h4321, 1'b1, "R1");

        // R6: block terms independent of the carry-in.
        run_vec(16'hF0F0, 16'h0F1F, 1'b0, "R6");
        p0 = blk_prop; g0 = blk_gen;
        run_vec(16'hF0F0, 16'h0F1F, 1'b1, "R6");
        check_val("R6", "blk_prop vs cin", int'(blk_prop), int'(p0));
        check_val("R6", "blk_gen vs cin", int'(blk_gen), int'(g0));

        // R8: no memory of earlier operands.
        run_vec(16'hFFFF, 16'hFFFF, 1'b1, "R8");
        run_vec(16'h0000, 16'h0000, 1'b0, "R8");

        for (int i = 0; i < 600; i++) begin
            run_vec(16'($urandom), 16'($urandom), 1'($urandom), "R1");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule